// File: doc/BRIEF.md
# Serial Interface Configuration Register File

This block holds the configuration and control state for a four-data-line serial peripheral engine. Two 16-bit registers sit on a simple single-cycle register bus. The first is a role/transfer-mode register. The second is a control register. The control register carries the data-line direction, the select-pin level, a self-clearing engine reset and the module enable.

The block drives the engine with its role, transfer mode, effective line direction, select level, a registered clock enable and a fixed-length reset pulse. The role/transfer-mode register is locked while the module is enabled. In hardware-driven (memory-mapped) operation, reading the select bit returns the live pin level reported by the engine. Otherwise it returns the stored value.

Top module: `serial_cfg_regs`

## Requirements
- R1: After synchronous reset the mode register (address 0) reads 0x0000 and the control register (address 1) reads 0x0004. `clk_en_o`, `eng_rst_o`, `dir_in_o` and `role_master_o` are 0, `xfer_mode_o` is 0 and `ss_level_o` is 1.
- R2: In the mode register, bit 0 is the role (1 = master, 0 = slave) and bits [3:2] are the transfer mode. These fields drive `role_master_o` and `xfer_mode_o` from the cycle after the write. All other mode bits read 0.
- R3: A write to address 0 is ignored while the enable bit is 1 at the time of the write.
- R4: In the control register, bit 3 is direction, bit 2 is select level, bit 1 is software reset and bit 0 is enable. Bits 15:4 always read 0.
- R5: `dir_in_o` equals the direction bit (1 = input) only when the transfer mode is 1 or 2. For transfer modes 0 and 3 it is 0.
- R6: `ss_level_o` follows control bit 2 (1 = high/deselected). When `mm_mode_i` is 1, a read of bit 2 returns `eng_ss_i` instead of the stored bit.
- R7: Writing 1 to control bit 1 raises `eng_rst_o` from the next cycle for exactly 3 cycles, during which bit 1 reads 1. A new 1 written while the pulse is active restarts the 3 cycles. Writing 0 to the bit has no effect.
- R8: `clk_en_o` follows the enable bit from the cycle after the write.
- R9: `bus_rdata` is 0 when `bus_rd` is low or when the address is neither 0 nor 1. Writes to other addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| mm_mode_i | input | 1 | Engine is in hardware-driven memory-mapped operation |
| eng_ss_i | input | 1 | Live select-pin level from the engine |
| role_master_o | output | 1 | 1 = master role |
| xfer_mode_o | output | 2 | Transfer mode |
| dir_in_o | output | 1 | Effective data-line direction, 1 = input |
| ss_level_o | output | 1 | Select-pin level request |
| clk_en_o | output | 1 | Engine clock enable |
| eng_rst_o | output | 1 | Engine shift-register/counter reset pulse |

## Verification
The mode register is written with all-ones and with each transfer-mode value while direction is set. This separates correct direction gating for modes 1 and 2 from gating on the wrong codes. Mode writes are repeated with the enable set and then cleared, which separates a lock taken from the current enable from no lock at all. Reset-bit writes cover an isolated 1, a 0 while busy, and a 1 mid-pulse, which tell a fixed-length, restartable pulse apart from a one-shot or level-following one. Select reads are made with `mm_mode_i` low and high while `eng_ss_i` toggles, and bus traffic goes to unused addresses.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int MODE_ROLE_BIT = 0;
  localparam int MODE_XFER_LO  = 2;
  localparam int MODE_XFER_HI  = 3;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 1;
  localparam int CTRL_SS_BIT   = 2;
  localparam int CTRL_DIR_BIT  = 3;
  localparam int ADR_MODE      = 0;
  localparam int ADR_CTRL      = 1;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_DUAL   = 2'd1,
    XM_QUAD   = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/scr_mode_reg.sv
module scr_mode_reg
  import scr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [DW-1:0] wdata_i,
  output logic          role_o,
  output xfer_mode_e    xmode_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      role_o  <= 1'b0;
      xmode_o <= XM_SINGLE;
    end else if (we_i && !lock_i) begin
      role_o  <= wdata_i[MODE_ROLE_BIT];
      xmode_o <= xfer_mode_e'(wdata_i[MODE_XFER_HI:MODE_XFER_LO]);
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> ($stable(role_o) && $stable(xmode_o)));  // R3
endmodule

// File: rtl/scr_rst_seq.sv
module scr_rst_seq #(
  parameter int CYCLES = 3,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start_i)           cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_o <= (cnt_d != '0);
    end
  end

  AST_RST_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);  // R7
  AST_RST_END: assert property (@(posedge clk) disable iff (rst)
    (!start_i && cnt_q == CW'(1)) |=> !busy_o);  // R7
endmodule

// File: rtl/scr_ctrl_reg.sv
module scr_ctrl_reg
  import scr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          dir_o,
  output logic          ss_o,
  output logic          en_o,
  output logic          srst_start_o
);
  assign srst_start_o = we_i && wdata_i[CTRL_SRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_o <= 1'b0;
      ss_o  <= 1'b1;
      en_o  <= 1'b0;
    end else if (we_i) begin
      dir_o <= wdata_i[CTRL_DIR_BIT];
      ss_o  <= wdata_i[CTRL_SS_BIT];
      en_o  <= wdata_i[CTRL_EN_BIT];
    end
  end

  AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (en_o == $past(wdata_i[CTRL_EN_BIT])));  // R8
  AST_SS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(ss_o));  // R6
endmodule

// File: rtl/scr_rdmux.sv
module scr_rdmux
  import scr_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          role_i,
  input  xfer_mode_e    xmode_i,
  input  logic          dir_i,
  input  logic          ss_i,
  input  logic          busy_i,
  input  logic          en_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == AW'(ADR_MODE)) begin
        rdata_o[MODE_ROLE_BIT]              = role_i;
        rdata_o[MODE_XFER_HI:MODE_XFER_LO]  = xmode_i;
      end else if (addr_i == AW'(ADR_CTRL)) begin
        rdata_o[CTRL_DIR_BIT]  = dir_i;
        rdata_o[CTRL_SS_BIT]   = ss_i;
        rdata_o[CTRL_SRST_BIT] = busy_i;
        rdata_o[CTRL_EN_BIT]   = en_i;
      end
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata_o[DW-1:4] == '0);  // R4
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_i |-> (rdata_o == '0));  // R9
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import scr_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 2,
  parameter int RST_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          mm_mode_i,
  input  logic          eng_ss_i,
  output logic          role_master_o,
  output logic [1:0]    xfer_mode_o,
  output logic          dir_in_o,
  output logic          ss_level_o,
  output logic          clk_en_o,
  output logic          eng_rst_o
);
  logic       we_mode, we_ctrl, dir_q, ss_q, en_q, srst_start, ss_rd;
  xfer_mode_e xmode;

  assign we_mode = bus_wr && (bus_addr == AW'(ADR_MODE));
  assign we_ctrl = bus_wr && (bus_addr == AW'(ADR_CTRL));

  scr_mode_reg #(.DW(DW)) u_mode (
    .clk(clk), .rst(rst), .we_i(we_mode), .lock_i(en_q),
    .wdata_i(bus_wdata), .role_o(role_master_o), .xmode_o(xmode)
  );

  scr_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .we_i(we_ctrl), .wdata_i(bus_wdata),
    .dir_o(dir_q), .ss_o(ss_q), .en_o(en_q), .srst_start_o(srst_start)
  );

  scr_rst_seq #(.CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .start_i(srst_start), .busy_o(eng_rst_o)
  );

  assign ss_rd = mm_mode_i ? eng_ss_i : ss_q;

  scr_rdmux #(.DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_i(bus_rd), .addr_i(bus_addr),
    .role_i(role_master_o), .xmode_i(xmode), .dir_i(dir_q),
    .ss_i(ss_rd), .busy_i(eng_rst_o), .en_i(en_q), .rdata_o(bus_rdata)
  );

  assign xfer_mode_o = xmode;
  assign dir_in_o    = dir_q && ((xmode == XM_DUAL) || (xmode == XM_QUAD));
  assign ss_level_o  = ss_q;
  assign clk_en_o    = en_q;

  AST_DIR_NARROW_OFF: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode_o == 2'd0 || xfer_mode_o == 2'd3) |-> !dir_in_o);  // R5
  AST_LOCKED_WHILE_CLOCKED: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && bus_wr && bus_addr == AW'(ADR_MODE)) |=> $stable(xfer_mode_o));  // R3
endmodule

// File: tb/sim_serial_cfg_regs.sv
`timescale 1ns/1ps
module sim_serial_cfg_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        mm_mode_i, eng_ss_i;
  logic        role_master_o, dir_in_o, ss_level_o, clk_en_o, eng_rst_o;
  logic [1:0]  xfer_mode_o;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  int m_role, m_tmode, m_dir, m_ss, m_en, m_cnt;

  always #2 clk = ~clk;

  serial_cfg_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mm_mode_i(mm_mode_i),
    .eng_ss_i(eng_ss_i), .role_master_o(role_master_o), .xfer_mode_o(xfer_mode_o),
    .dir_in_o(dir_in_o), .ss_level_o(ss_level_o), .clk_en_o(clk_en_o),
    .eng_rst_o(eng_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 0) return m_role | (m_tmode << 2);
    if (a == 1) return (m_dir << 3) | ((mm_mode_i ? int'(eng_ss_i) : m_ss) << 2)
                       | ((m_cnt > 0 ? 1 : 0) << 1) | m_en;
    return 0;
  endfunction

  task automatic cmp_outputs();
    chk("R2 role", int'(role_master_o), m_role);
    chk("R2 xfer", int'(xfer_mode_o), m_tmode);
    chk("R5 dir", int'(dir_in_o), (m_dir != 0 && (m_tmode == 1 || m_tmode == 2)) ? 1 : 0);
    chk("R6 ss", int'(ss_level_o), m_ss);
    chk("R8 clk_en", int'(clk_en_o), m_en);
    chk("R7 eng_rst", int'(eng_rst_o), m_cnt > 0 ? 1 : 0);
  endtask

  task automatic model_clock(input int a, input bit w, input int d);
    if (rst) begin
      m_role = 0; m_tmode = 0; m_dir = 0; m_ss = 1; m_en = 0; m_cnt = 0;
    end else begin
      if (m_cnt > 0) m_cnt--;
      if (w && a == 0 && m_en == 0) begin
        m_role = d & 1; m_tmode = (d >> 2) & 3;
      end
      if (w && a == 1) begin
        m_dir = (d >> 3) & 1; m_ss = (d >> 2) & 1; m_en = d & 1;
        if (((d >> 1) & 1) != 0) m_cnt = 3;
      end
    end
  endtask

  task automatic cyc(input int a, input bit w, input bit r, input int d);
    @(negedge clk);
    cmp_outputs();
    bus_addr = a[1:0]; bus_wr = w; bus_rd = r; bus_wdata = d[15:0];
    #1;
    if (r) chk(a == 0 ? "R2 read" : (a == 1 ? "R4 read" : "R9 read"),
               int'(bus_rdata), model_read(a));
    else   chk("R9 idle read", int'(bus_rdata), 0);
    @(posedge clk);
    model_clock(a, w, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    mm_mode_i = 0; eng_ss_i = 0;
    m_role = 0; m_tmode = 0; m_dir = 0; m_ss = 1; m_en = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 explicit reset state
    chk("R1 clk_en", int'(clk_en_o), 0);
    chk("R1 eng_rst", int'(eng_rst_o), 0);
    chk("R1 ss", int'(ss_level_o), 1);
    chk("R1 role", int'(role_master_o), 0);
    bus_rd = 1; bus_addr = 1; #1;
    chk("R1 ctrl read", int'(bus_rdata), 16'h0004);
    bus_addr = 0; #1;
    chk("R1 mode read", int'(bus_rdata), 0);
    bus_rd = 0;
    // R2 all-ones mode write, reserved bits drop
    cyc(0, 1, 0, 16'hFFFF);
    cyc(0, 0, 1, 0);
    // R4 ctrl write with upper bits, dir=1 ss=0
    cyc(1, 1, 0, 16'hFFF8);
    cyc(1, 0, 1, 0);
    // R5 sweep transfer modes with dir=1
    for (int t = 0; t < 4; t++) begin
      cyc(0, 1, 0, (t << 2) | (t & 1));
      cyc(0, 0, 1, 0);
    end
    cyc(0, 1, 0, 16'h0004);
    // R8 enable, R3 lock
    cyc(1, 1, 0, 16'h0009);
    cyc(0, 1, 0, 16'h0009);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 16'h000C);
    cyc(0, 0, 1, 0);
    // R7 software reset pulse, reads during busy
    cyc(1, 1, 0, 16'h000B);
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0);
    // R7 write 0 while busy, then restart mid-pulse
    cyc(1, 1, 0, 16'h0003);
    cyc(1, 1, 0, 16'h0001);
    cyc(1, 1, 0, 16'h0003);
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0);
    // R6 select readback in memory-mapped mode
    cyc(1, 1, 0, 16'h0005);
    mm_mode_i = 1;
    for (int i = 0; i < 4; i++) begin
      eng_ss_i = i[0];
      cyc(1, 0, 1, 0);
    end
    mm_mode_i = 0;
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 16'h0000);
    cyc(1, 0, 1, 0);
    // R3 unlocked again after disable
    cyc(0, 1, 0, 16'h0009);
    cyc(0, 0, 1, 0);
    // R9 unused addresses
    cyc(2, 1, 0, 16'hFFFF);
    cyc(3, 1, 0, 16'hFFFF);
    cyc(2, 0, 1, 0);
    cyc(3, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule